// File: doc/BRIEF.md
# Binary Frequency-Search Tracker

This block steers the control word of a digitally controlled oscillator towards the frequency asked by a reference clock. Once per reference cycle a bang-bang detector says whether the oscillator should run faster or slower. The tracker adds the current step to the control word for a faster request and subtracts it for a slower one. The step is always a power of two, and the bit that holds it is called the active position.

Each time the detector changes its answer compared with the previous decision, the target frequency lies within one step of the word. The tracker then moves the active position down one bit, which halves the step, and applies the new step in the new direction. A reversal that arrives while the step is already one LSB ends the search. The frequency-locked flag rises and the word stays frozen until the next start. Because the step halves on every reversal, the number of reversals needed grows as log2 of the number of oscillator settings.

The controller has three states. ST_IDLE is entered from reset. ST_SEARCH is entered from any state when start is asserted. ST_LOCKED is entered from ST_SEARCH on a reversal at position 0. A start pulse in ST_SEARCH or ST_LOCKED restarts the search.

Top module: `fbs_tracker`

## Requirements
- R1: After reset the state is ST_IDLE, ctrl_word is mid-scale (only bit W_CTRL-1 set, 128 by default), step_pos is W_CTRL-1 and freq_lock is 0. Decisions in ST_IDLE change nothing.
- R2: A start pulse, in any state, loads the mid-scale word, sets step_pos to W_CTRL-1, clears freq_lock, forgets the previous decision and enters ST_SEARCH one clock later. A decision presented in the same cycle as start is ignored.
- R3: In ST_SEARCH, a valid up decision (dec_valid=1, dec_up=1) that repeats the previous direction adds 2^step_pos to ctrl_word. The result saturates at 2^W_CTRL-1.
- R4: In ST_SEARCH, a valid down decision (dec_valid=1, dec_up=0) that repeats the previous direction subtracts 2^step_pos from ctrl_word. The result saturates at 0.
- R5: A valid decision whose direction differs from the previous valid decision, with step_pos above 0, lowers step_pos by one and then moves ctrl_word by the halved step in the new direction, saturating as in R3 and R4.
- R6: The first valid decision after start is never taken as a reversal: it steps by 2^(W_CTRL-1) and leaves step_pos unchanged.
- R7: A reversal while step_pos is 0 sets freq_lock and enters ST_LOCKED without changing ctrl_word.
- R8: In ST_LOCKED, ctrl_word, step_pos and freq_lock stay unchanged for any decisions until start.
- R9: A cycle with dec_valid=0 and no start changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new search from mid-scale |
| dec_valid | input | 1 | One-cycle strobe: a detector decision is present |
| dec_up | input | 1 | Decision: 1 = run faster, 0 = run slower |
| ctrl_word | output | W_CTRL | Oscillator control word |
| step_pos | output | POS_W | Active bit position; the step is 2^step_pos |
| freq_lock | output | 1 | Frequency search finished |

## Verification
The assertions assume that start and dec_valid are clean synchronous levels. They also assume that the decision one cycle after a start is judged against the fresh search, so no stale direction may come from before the start. The stimulus drives both inputs only on the falling edge. It mixes purely random decisions with decisions taken from a bench-modelled oscillator target. It also inserts start pulses, including some that coincide with a decision, so restarts from mid-search and from lock are both exercised.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_LOCKED = 2'd2
    } fbs_state_e;
endpackage

// File: rtl/fbs_dir_memory.sv
// Remembers the direction of the last accepted decision and flags a reversal.
module fbs_dir_memory (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic capture,
    input  logic dir_up,
    output logic reversal
);
    logic prev_up;
    logic have_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_up   <= 1'b0;
            have_prev <= 1'b0;
        end else if (clear) begin
            have_prev <= 1'b0;
        end else if (capture) begin
            prev_up   <= dir_up;
            have_prev <= 1'b1;
        end
    end

    assign reversal = have_prev && (dir_up != prev_up);
endmodule

// File: rtl/fbs_sat_step.sv
// Saturating add or subtract of a power-of-two step.
module fbs_sat_step #(
    parameter int W_CTRL = 8,
    parameter int POS_W  = $clog2(W_CTRL)
) (
    input  logic [W_CTRL-1:0] word_in,
    input  logic [POS_W-1:0]  pos,
    input  logic              up,
    output logic [W_CTRL-1:0] word_out
);
    localparam logic [W_CTRL-1:0] FULL = {W_CTRL{1'b1}};

    logic [W_CTRL:0] step_ext;
    logic [W_CTRL:0] sum_ext;

    always_comb begin
        step_ext = (W_CTRL+1)'(1) << pos;
        sum_ext  = {1'b0, word_in} + step_ext;
        if (up) begin
            word_out = sum_ext[W_CTRL] ? FULL : sum_ext[W_CTRL-1:0];
        end else if ({1'b0, word_in} < step_ext) begin
            word_out = '0;
        end else begin
            word_out = word_in - step_ext[W_CTRL-1:0];
        end
    end
endmodule

// File: rtl/fbs_tracker.sv
module fbs_tracker
    import fbs_pkg::*;
#(
    parameter int W_CTRL = 8,
    parameter int POS_W  = $clog2(W_CTRL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dec_valid,
    input  logic              dec_up,
    output logic [W_CTRL-1:0] ctrl_word,
    output logic [POS_W-1:0]  step_pos,
    output logic              freq_lock
);
    localparam logic [W_CTRL-1:0] MID_WORD = W_CTRL'(1) << (W_CTRL - 1);
    localparam logic [POS_W-1:0]  TOP_POS  = POS_W'(W_CTRL - 1);

    fbs_state_e state, state_nx;

    logic             reversal;
    logic             accept;
    logic             at_lsb;
    logic [POS_W-1:0] eff_pos;
    logic [W_CTRL-1:0] stepped_word;

    assign accept = (state == ST_SEARCH) && dec_valid && !start;
    assign at_lsb = (step_pos == '0);
    assign eff_pos = (reversal && !at_lsb) ? step_pos - POS_W'(1) : step_pos;

    fbs_dir_memory u_dir (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start),
        .capture  (accept),
        .dir_up   (dec_up),
        .reversal (reversal)
    );

    fbs_sat_step #(
        .W_CTRL (W_CTRL),
        .POS_W  (POS_W)
    ) u_step (
        .word_in  (ctrl_word),
        .pos      (eff_pos),
        .up       (dec_up),
        .word_out (stepped_word)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_SEARCH;
            ST_SEARCH: begin
                if (start)                            state_nx = ST_SEARCH;
                else if (accept && reversal && at_lsb) state_nx = ST_LOCKED;
            end
            ST_LOCKED: if (start) state_nx = ST_SEARCH;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_word <= MID_WORD;
            step_pos  <= TOP_POS;
            freq_lock <= 1'b0;
        end else if (start) begin
            ctrl_word <= MID_WORD;
            step_pos  <= TOP_POS;
            freq_lock <= 1'b0;
        end else if (accept) begin
            if (reversal && at_lsb) begin
                freq_lock <= 1'b1;
            end else begin
                step_pos  <= eff_pos;
                ctrl_word <= stepped_word;
            end
        end
    end
endmodule

// File: rtl/fbs_tracker_chk.sv
module fbs_tracker_chk #(
    parameter int W_CTRL = 8,
    parameter int POS_W  = $clog2(W_CTRL)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              dec_valid,
    input logic              dec_up,
    input logic [W_CTRL-1:0] ctrl_word,
    input logic [POS_W-1:0]  step_pos,
    input logic              freq_lock
);
    localparam logic [W_CTRL-1:0] MID_WORD = W_CTRL'(1) << (W_CTRL - 1);
    localparam logic [POS_W-1:0]  TOP_POS  = POS_W'(W_CTRL - 1);

    AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (ctrl_word == MID_WORD) && (step_pos == TOP_POS) && !freq_lock); // R2

    AST_UP_NOT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_up && !start && !freq_lock) |=> ctrl_word >= $past(ctrl_word)); // R3

    AST_DOWN_NOT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_up && !start && !freq_lock) |=> ctrl_word <= $past(ctrl_word)); // R4

    AST_POS_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> step_pos <= $past(step_pos)); // R5

    AST_FIRST_NO_REV: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(start) && dec_valid && !start) |=> step_pos == $past(step_pos)); // R6

    AST_LOCK_AT_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        freq_lock |-> step_pos == '0); // R7

    AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_lock && !start) |=> freq_lock && $stable(ctrl_word) && $stable(step_pos)); // R8

    AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_valid && !start) |=> $stable(ctrl_word) && $stable(step_pos) && $stable(freq_lock)); // R9
endmodule

bind fbs_tracker fbs_tracker_chk #(
    .W_CTRL (W_CTRL),
    .POS_W  (POS_W)
) u_chk (.*);

// File: tb/fbs_tracker_bench.sv
module fbs_tracker_bench;
    localparam int W     = 8;
    localparam int PW    = $clog2(W);
    localparam int FULL  = (1 << W) - 1;
    localparam int MID   = 1 << (W - 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          dec_valid = 1'b0;
    logic          dec_up = 1'b0;
    logic [W-1:0]  ctrl_word;
    logic [PW-1:0] step_pos;
    logic          freq_lock;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // Bench model
    int m_word = MID;
    int m_pos  = W - 1;
    bit m_lock = 0;
    bit m_run  = 0;
    bit m_have = 0;
    bit m_prev = 0;

    always #10 clk = ~clk;

    fbs_tracker #(.W_CTRL(W), .POS_W(PW)) u_fbs_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .dec_valid (dec_valid),
        .dec_up    (dec_up),
        .ctrl_word (ctrl_word),
        .step_pos  (step_pos),
        .freq_lock (freq_lock)
    );

    function automatic int sat_move(int w, int p, bit up);
        int r;
        r = up ? w + (1 << p) : w - (1 << p);
        if (r > FULL) r = FULL;
        if (r < 0) r = 0;
        return r;
    endfunction

    task automatic model_step(bit s, bit v, bit u);
        if (s) begin
            m_word = MID; m_pos = W - 1; m_lock = 0; m_run = 1; m_have = 0;
        end else if (v && m_run && !m_lock) begin
            if (m_have && (u != m_prev)) begin
                if (m_pos == 0) m_lock = 1;
                else begin
                    m_pos  = m_pos - 1;
                    m_word = sat_move(m_word, m_pos, u);
                end
            end else begin
                m_word = sat_move(m_word, m_pos, u);
            end
            m_prev = u; m_have = 1;
        end
    endtask

    task automatic compare(string tag);
        n_checks++;
        if (ctrl_word !== W'(m_word) || step_pos !== PW'(m_pos) || freq_lock !== m_lock) begin
            n_fail++;
            $display("FAIL %s: word=%0d pos=%0d lock=%0b expected word=%0d pos=%0d lock=%0b",
                     tag, ctrl_word, step_pos, freq_lock, m_word, m_pos, m_lock);
        end
    endtask

    // Called at a falling edge: check previous result, then apply new inputs.
    task automatic cycle(bit s, bit v, bit u, string tag);
        @(negedge clk);
        compare(tag);
        start = s; dec_valid = v; dec_up = u;
        model_step(s, v, u);
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        report();
    end

    initial begin
        int target;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
        // R1: decisions before any start are ignored
        cycle(0, 1, 1, "R1");
        cycle(0, 1, 0, "R1 idle ignore");
        // R2 start, R6 first decision, R3 saturation at top
        cycle(1, 0, 0, "R1");
        cycle(0, 1, 1, "R2 start load");
        cycle(0, 1, 1, "R6 first not reversal");
        cycle(0, 0, 0, "R3 saturate top");
        cycle(0, 1, 0, "R9 no strobe hold");
        cycle(0, 1, 0, "R5 reversal halves");
        cycle(0, 1, 0, "R4 down step");
        cycle(0, 1, 0, "R4 down step");
        cycle(0, 1, 1, "R4 saturate zero");
        // alternating decisions walk down to lock
        for (int i = 0; i < 10; i++) cycle(0, 1, (i % 2) == 0, "R5 R7 alternate");
        for (int i = 0; i < 6; i++) cycle(0, 1, i[0], "R7 lock");
        // R2: start coinciding with decision
        cycle(1, 1, 1, "R8 locked frozen");
        cycle(0, 1, 0, "R2 start beats decision");
        cycle(0, 0, 0, "R6 down first");
        // random decisions with random restarts
        for (int i = 0; i < 3000; i++) begin
            bit s = ($urandom % 40) == 0;
            cycle(s, ($urandom % 3) != 0, $urandom % 2, "R3 R4 R5 R9 random");
        end
        // target-driven searches
        for (int k = 0; k < 40; k++) begin
            target = $urandom % (FULL + 1);
            cycle(1, 0, 0, "R2 search");
            for (int i = 0; i < 40; i++) begin
                cycle(0, ($urandom % 4) != 0, (m_word < target), "R5 R7 R8 search");
            end
        end
        cycle(0, 0, 0, "R8 final");
        @(negedge clk);
        compare("R9 final");
        report();
    end
endmodule